// File: doc/BRIEF.md
# Scaler Mode and Factor Calculator

This block works out, for each axis of a video scaler, whether the picture passes straight through, is enlarged or is reduced. It also computes the fixed-point step that the interpolation stage advances by for each output pixel or line. Software or a sequencer applies the source and destination active sizes and a reduction-style select bit per axis, then pulses `start`. The block captures those inputs and runs one shared divider, first for the horizontal axis and then for the vertical axis. It raises `done` for a single cycle once both results are in the output registers.

Division uses a restoring shift-subtract divider that produces one quotient bit per clock. The numerator is the larger size operand shifted left by a fraction width that depends on the scaling direction. Divisors of zero are caught before they corrupt a result. The outputs hold their values until the next accepted start.

Top module: `scaleFactorCalc`

## Requirements
- R1: Each axis mode is 0 when source and destination sizes are equal. It is 1 when the source is smaller (enlarge) and 2 when the source is larger (reduce). Mode 3 never appears.
- R2: In mode 0 the factor of that axis is 0.
- R3: In mode 1 the factor is floor(((src-1) * 65536) / (dst-1)). The select bit has no effect in mode 1.
- R4: In mode 2 with select 0, when floor((src-1)/(dst-1)) is greater than 2, the factor is floor(((src-1) * 16384) / (dst-1)).
- R5: In mode 2 with select 0, when floor((src-1)/(dst-1)) is 2 or less, the factor is floor(((src-2) * 16384) / (dst-1)).
- R6: In mode 2 with select 1, the factor is floor((dst * 65536) / (src-1)). A destination of 1 is legal here.
- R7: Width and height are handled by identical rules, each from its own sizes and select bit. One axis never affects the other.
- R8: A required divisor of zero (for example reduce, select 0, destination 1) sets `zeroDiv` and forces that axis factor to 0. `zeroDiv` clears at the next accepted start. Mode 0 never sets it.
- R9: A factor is the low 16 bits of the full quotient. For example, 3999*16384/99 shows only its low 16 bits, and 499*65536/499 = 65536 shows as 0.
- R10: `start` is accepted only while `busy` and `done` are both low. The inputs are captured at that edge. `busy` is high from the following cycle until `done`. A start while busy is ignored and does not disturb the run in progress.
- R11: After reset, both modes, both factors, `zeroDiv`, `busy` and `done` are 0. Outputs change only during a run and then hold while idle.
- R12: `done` rises 2*(SIZE_W+16)+4 clock edges after the edge that accepts start, which is 62 edges with defaults. It lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a calculation; sampled only when idle |
| srcWidth | input | 13 | Source active width |
| srcHeight | input | 13 | Source active height |
| dstWidth | input | 13 | Destination active width |
| dstHeight | input | 13 | Destination active height |
| hDownSel | input | 1 | Horizontal reduce style: 0 ratio-based, 1 reciprocal |
| vDownSel | input | 1 | Vertical reduce style: 0 ratio-based, 1 reciprocal |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse when both axes are stored |
| hMode | output | 2 | Horizontal mode (0 bypass, 1 enlarge, 2 reduce) |
| hFactor | output | 16 | Horizontal step factor |
| vMode | output | 2 | Vertical mode |
| vFactor | output | 16 | Vertical step factor |
| zeroDiv | output | 1 | A required divisor was zero in the last run |

## Verification
Some properties are checked on every cycle. These are the legal mode encoding, the zero factor whenever a mode is bypass, the zero factor that goes with a raised `zeroDiv`, and the single-cycle `done`. The same checks cover the step from an accepted start into `busy`, and the outputs holding still while idle. The bench scenarios are the only way to show the arithmetic. That means the choice between the two ratio-dependent numerators, the reciprocal reduce form, truncation to 16 bits, exact latency, and independence of the axes. The scenarios also show that a start issued mid-run changes neither the results nor the number of completions.

// File: rtl/scf_pkg.sv
package scf_pkg;
  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_UP     = 2'd1,
    MODE_DOWN   = 2'd2
  } scaleMode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DIV,
    ST_STORE,
    ST_DONE
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch the block inputs
    logic load;     // load divider with the selected axis operands
    logic step;     // one restoring iteration
    logic store;    // write the selected axis result
    logic axisV;    // 0 = horizontal, 1 = vertical
  } ctrlStrobe_t;
endpackage

// File: rtl/scf_axis_prep.sv
module scf_axis_prep
  import scf_pkg::*;
#(
  parameter int SIZE_W  = 13,
  parameter int UP_FRAC = 16,
  parameter int DN_FRAC = 14,
  localparam int NUM_W  = SIZE_W + UP_FRAC
) (
  input  logic [SIZE_W-1:0] src,
  input  logic [SIZE_W-1:0] dst,
  input  logic              downSel,
  output scaleMode_e        mode,
  output logic [NUM_W-1:0]  numer,
  output logic [SIZE_W-1:0] divisor,
  output logic              zeroDiv
);
  logic [SIZE_W-1:0] srcM1, srcM2, dstM1;
  logic [SIZE_W+1:0] tripleDst;
  logic              ratioAbove2;

  always_comb begin
    srcM1       = src - SIZE_W'(1);
    srcM2       = src - SIZE_W'(2);
    dstM1       = dst - SIZE_W'(1);
    // floor(a/b) > 2  <=>  a >= 3*b
    tripleDst   = {2'b00, dstM1} + {1'b0, dstM1, 1'b0};
    ratioAbove2 = {2'b00, srcM1} >= tripleDst;
    numer       = '0;
    divisor     = dstM1;
    if (src == dst) begin
      mode = MODE_BYPASS;
    end else if (src < dst) begin
      mode  = MODE_UP;
      numer = NUM_W'(srcM1) << UP_FRAC;
    end else begin
      mode = MODE_DOWN;
      if (downSel) begin
        numer   = NUM_W'(dst) << UP_FRAC;
        divisor = srcM1;
      end else if (ratioAbove2) begin
        numer = NUM_W'(srcM1) << DN_FRAC;
      end else begin
        numer = NUM_W'(srcM2) << DN_FRAC;
      end
    end
    zeroDiv = (mode != MODE_BYPASS) && (divisor == '0);
  end
endmodule

// File: rtl/scf_ctrl.sv
module scf_ctrl
  import scf_pkg::*;
#(
  parameter int NUM_W = 29,
  localparam int CNT_W = $clog2(NUM_W)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output ctrlStrobe_t ctl,
  output logic        busy,
  output logic        done
);
  ctrlState_e state, stateNext;
  logic [CNT_W-1:0] bitCnt;
  logic axisV;

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    ctl.axisV   = axisV;
    unique case (state)
      ST_IDLE:  if (start) begin
                  ctl.capture = 1'b1;
                  stateNext   = ST_LOAD;
                end
      ST_LOAD:  begin
                  ctl.load  = 1'b1;
                  stateNext = ST_DIV;
                end
      ST_DIV:   begin
                  ctl.step = 1'b1;
                  if (bitCnt == CNT_W'(NUM_W - 1)) stateNext = ST_STORE;
                end
      ST_STORE: begin
                  ctl.store = 1'b1;
                  stateNext = axisV ? ST_DONE : ST_LOAD;
                end
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      axisV  <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctl.capture) axisV <= 1'b0;
      else if (ctl.store) axisV <= 1'b1;
      if (ctl.load) bitCnt <= '0;
      else if (ctl.step) bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  assign busy = (state != ST_IDLE) && (state != ST_DONE);
  assign done = (state == ST_DONE);
endmodule

// File: rtl/scf_datapath.sv
module scf_datapath
  import scf_pkg::*;
#(
  parameter int SIZE_W  = 13,
  parameter int FACT_W  = 16,
  parameter int UP_FRAC = 16,
  parameter int DN_FRAC = 14,
  localparam int NUM_W  = SIZE_W + UP_FRAC
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       ctl,
  input  logic [SIZE_W-1:0] srcWidth,
  input  logic [SIZE_W-1:0] srcHeight,
  input  logic [SIZE_W-1:0] dstWidth,
  input  logic [SIZE_W-1:0] dstHeight,
  input  logic              hDownSel,
  input  logic              vDownSel,
  output logic [1:0]        hMode,
  output logic [FACT_W-1:0] hFactor,
  output logic [1:0]        vMode,
  output logic [FACT_W-1:0] vFactor,
  output logic              zeroDiv
);
  logic [SIZE_W-1:0] capSrc [2];
  logic [SIZE_W-1:0] capDst [2];
  logic [1:0]        capSel;

  scaleMode_e        prepMode [2];
  logic [NUM_W-1:0]  prepNumer [2];
  logic [SIZE_W-1:0] prepDiv [2];
  logic [1:0]        prepZero;

  for (genvar ax = 0; ax < 2; ax++) begin : gAxis
    scf_axis_prep #(.SIZE_W(SIZE_W), .UP_FRAC(UP_FRAC), .DN_FRAC(DN_FRAC)) uPrep (
      .src(capSrc[ax]), .dst(capDst[ax]), .downSel(capSel[ax]),
      .mode(prepMode[ax]), .numer(prepNumer[ax]), .divisor(prepDiv[ax]),
      .zeroDiv(prepZero[ax])
    );
  end

  logic [NUM_W-1:0]  quo;
  logic [SIZE_W-1:0] rem, divR;
  scaleMode_e        curMode;
  logic              curErr;
  logic [SIZE_W:0]   trial;
  logic              fits;
  logic [FACT_W-1:0] result;

  always_comb begin
    trial  = {rem, quo[NUM_W-1]};
    fits   = trial >= {1'b0, divR};
    result = (curMode == MODE_BYPASS || curErr) ? '0 : quo[FACT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capSrc[0] <= '0; capSrc[1] <= '0;
      capDst[0] <= '0; capDst[1] <= '0;
      capSel    <= '0;
      quo       <= '0;
      rem       <= '0;
      divR      <= '0;
      curMode   <= MODE_BYPASS;
      curErr    <= 1'b0;
      hMode     <= '0;
      hFactor   <= '0;
      vMode     <= '0;
      vFactor   <= '0;
      zeroDiv   <= 1'b0;
    end else begin
      if (ctl.capture) begin
        capSrc[0] <= srcWidth;  capDst[0] <= dstWidth;
        capSrc[1] <= srcHeight; capDst[1] <= dstHeight;
        capSel    <= {vDownSel, hDownSel};
        zeroDiv   <= 1'b0;
      end
      if (ctl.load) begin
        quo     <= prepNumer[ctl.axisV];
        rem     <= '0;
        divR    <= prepDiv[ctl.axisV];
        curMode <= prepMode[ctl.axisV];
        curErr  <= prepZero[ctl.axisV];
      end else if (ctl.step) begin
        rem <= fits ? SIZE_W'(trial - {1'b0, divR}) : trial[SIZE_W-1:0];
        quo <= {quo[NUM_W-2:0], fits};
      end
      if (ctl.store) begin
        if (ctl.axisV) begin
          vMode   <= curMode;
          vFactor <= result;
        end else begin
          hMode   <= curMode;
          hFactor <= result;
        end
        zeroDiv <= zeroDiv | curErr;
      end
    end
  end
endmodule

// File: rtl/scaleFactorCalc.sv
module scaleFactorCalc
  import scf_pkg::*;
#(
  parameter int SIZE_W  = 13,
  parameter int FACT_W  = 16,
  parameter int UP_FRAC = 16,
  parameter int DN_FRAC = 14,
  localparam int NUM_W  = SIZE_W + UP_FRAC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [SIZE_W-1:0] srcWidth,
  input  logic [SIZE_W-1:0] srcHeight,
  input  logic [SIZE_W-1:0] dstWidth,
  input  logic [SIZE_W-1:0] dstHeight,
  input  logic              hDownSel,
  input  logic              vDownSel,
  output logic              busy,
  output logic              done,
  output logic [1:0]        hMode,
  output logic [FACT_W-1:0] hFactor,
  output logic [1:0]        vMode,
  output logic [FACT_W-1:0] vFactor,
  output logic              zeroDiv
);
  ctrlStrobe_t ctl;

  scf_ctrl #(.NUM_W(NUM_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .ctl(ctl), .busy(busy), .done(done)
  );

  scf_datapath #(.SIZE_W(SIZE_W), .FACT_W(FACT_W), .UP_FRAC(UP_FRAC),
                 .DN_FRAC(DN_FRAC)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .srcWidth(srcWidth), .srcHeight(srcHeight),
    .dstWidth(dstWidth), .dstHeight(dstHeight),
    .hDownSel(hDownSel), .vDownSel(vDownSel),
    .hMode(hMode), .hFactor(hFactor), .vMode(vMode), .vFactor(vFactor),
    .zeroDiv(zeroDiv)
  );
endmodule

// File: rtl/scf_checker.sv
module scf_checker #(
  parameter int FACT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [1:0]        hMode,
  input logic [FACT_W-1:0] hFactor,
  input logic [1:0]        vMode,
  input logic [FACT_W-1:0] vFactor,
  input logic              zeroDiv
);
  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (hMode != 2'd3) && (vMode != 2'd3));

  a_r2_bypass_zero_h: assert property (@(posedge clk) disable iff (!rstN)
    (done && hMode == 2'd0) |-> hFactor == '0);

  a_r2_bypass_zero_v: assert property (@(posedge clk) disable iff (!rstN)
    (done && vMode == 2'd0) |-> vFactor == '0);

  a_r8_err_zero_factor: assert property (@(posedge clk) disable iff (!rstN)
    (done && zeroDiv) |-> (hFactor == '0 || vFactor == '0));

  a_r10_start_accept: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done) |=> busy);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> ($stable(hFactor) && $stable(vFactor) &&
      $stable(hMode) && $stable(vMode) && $stable(zeroDiv)));
endmodule

bind scaleFactorCalc scf_checker #(.FACT_W(FACT_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .hMode(hMode), .hFactor(hFactor), .vMode(vMode), .vFactor(vFactor),
  .zeroDiv(zeroDiv)
);

// File: tb/scaleFactorCalc_test.sv
module scaleFactorCalc_test;
  localparam int SIZE_W = 13;
  localparam int FACT_W = 16;
  localparam int NUM_W  = SIZE_W + 16;
  localparam int LAT    = 2 * NUM_W + 5;  // posedges counted incl. the accepting edge

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, start, hDownSel, vDownSel;
  logic [SIZE_W-1:0] srcWidth, srcHeight, dstWidth, dstHeight;
  logic busy, done, zeroDiv;
  logic [1:0] hMode, vMode;
  logic [FACT_W-1:0] hFactor, vFactor;

  scaleFactorCalc uut (
    .clk(clk), .rstN(rstN), .start(start),
    .srcWidth(srcWidth), .srcHeight(srcHeight),
    .dstWidth(dstWidth), .dstHeight(dstHeight),
    .hDownSel(hDownSel), .vDownSel(vDownSel),
    .busy(busy), .done(done), .hMode(hMode), .hFactor(hFactor),
    .vMode(vMode), .vFactor(vFactor), .zeroDiv(zeroDiv)
  );

  typedef struct {
    logic [1:0]  hm;
    logic [15:0] hf;
    logic [1:0]  vm;
    logic [15:0] vf;
    logic        err;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t last;
  int checks = 0;
  int errors = 0;

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void axisModel(input int src, input int dst, input bit sel,
                                    output logic [1:0] m, output logic [15:0] f,
                                    output bit e);
    longint q;
    e = 0; f = '0; q = 0;
    if (src == dst) m = 2'd0;
    else if (src < dst) begin
      m = 2'd1;
      if (dst - 1 == 0) e = 1;
      else begin q = (longint'(src - 1) * 65536) / (dst - 1); f = 16'(q); end
    end else begin
      m = 2'd2;
      if (sel) begin
        q = (longint'(dst) * 65536) / (src - 1); f = 16'(q);
      end else if (dst - 1 == 0) e = 1;
      else if ((src - 1) / (dst - 1) > 2) begin
        q = (longint'(src - 1) * 16384) / (dst - 1); f = 16'(q);
      end else begin
        q = (longint'(src - 2) * 16384) / (dst - 1); f = 16'(q);
      end
    end
  endfunction

  // driver: queue expected result, start, measure latency, check idle hold
  task automatic runJob(input int sw, input int sh, input int dw, input int dh,
                        input bit hs, input bit vs, input string tag,
                        input bit disturb);
    exp_t e;
    bit he, ve;
    int n;
    axisModel(sw, dw, hs, e.hm, e.hf, he);
    axisModel(sh, dh, vs, e.vm, e.vf, ve);
    e.err = he | ve;
    e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    srcWidth = SIZE_W'(sw); srcHeight = SIZE_W'(sh);
    dstWidth = SIZE_W'(dw); dstHeight = SIZE_W'(dh);
    hDownSel = hs; vDownSel = vs;
    start = 1'b1;
    n = 0;
    forever begin
      @(posedge clk); #1;
      n++;
      if (n == 1) begin
        start = 1'b0;
        check("R10", "busy after accept", longint'(busy), 1);
      end
      if (disturb && n == 5) begin
        srcWidth = 13'd77; dstWidth = 13'd1; srcHeight = 13'd5; dstHeight = 13'd900;
        start = 1'b1;
      end
      if (disturb && n == 6) start = 1'b0;
      if (done || n > 1000) break;
    end
    check("R12", "latency", longint'(n), longint'(LAT));
    repeat (10) @(negedge clk);
    check("R11", "idle busy", longint'(busy), 0);
    check("R11", "hold hFactor", longint'(hFactor), longint'(e.hf));
    check("R11", "hold vFactor", longint'(vFactor), longint'(e.vf));
  endtask

  // monitor: pop and compare on every done
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (rstN === 1'b1 && done === 1'b1) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R10 unexpected done actual=1 expected=0");
        end else begin
          e = sb.pop_front();
          check("R1", {e.tag, " hMode"}, longint'(hMode), longint'(e.hm));
          check("R1", {e.tag, " vMode"}, longint'(vMode), longint'(e.vm));
          check(e.tag, "hFactor", longint'(hFactor), longint'(e.hf));
          check(e.tag, "vFactor", longint'(vFactor), longint'(e.vf));
          check("R8", {e.tag, " zeroDiv"}, longint'(zeroDiv), longint'(e.err));
          last = e;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; hDownSel = 1'b0; vDownSel = 1'b0;
    srcWidth = '0; srcHeight = '0; dstWidth = '0; dstHeight = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "reset hMode", longint'(hMode), 0);
    check("R11", "reset vMode", longint'(vMode), 0);
    check("R11", "reset hFactor", longint'(hFactor), 0);
    check("R11", "reset vFactor", longint'(vFactor), 0);
    check("R11", "reset flags", longint'({busy, done, zeroDiv}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    runJob(1920, 1080, 1280, 720, 0, 0, "R5", 0);   // ratio <= 2 both axes
    runJob(720, 480, 1920, 1080, 1, 0, "R3", 0);    // enlarge, select ignored
    runJob(800, 600, 800, 300, 0, 0, "R2", 0);      // h bypass, v ratio exactly 2
    runJob(4000, 3000, 100, 1000, 0, 0, "R4", 0);   // ratio > 2; h wraps
    runJob(4000, 16, 100, 2, 0, 0, "R9", 0);        // large quotients truncated
    runJob(1000, 1000, 600, 1200, 1, 1, "R6", 0);   // h reciprocal, v enlarge
    runJob(500, 20, 499, 10, 1, 0, "R9", 0);        // 65536 truncates to 0
    runJob(300, 200, 1, 100, 0, 0, "R8", 0);        // zero divisor on h
    runJob(300, 200, 1, 100, 1, 0, "R6", 0);        // reciprocal with dst 1 is legal
    runJob(64, 64, 64, 64, 1, 1, "R8", 0);          // flag cleared, bypass both
    runJob(1280, 720, 1920, 360, 0, 1, "R7", 0);    // axes in opposite directions
    runJob(640, 480, 320, 960, 0, 0, "R10", 1);     // start mid-run ignored
    repeat (80) @(negedge clk);
    check("R10", "no extra completion", longint'(sb.size()), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule